// File: doc/BRIEF.md
# Power-Management Control Register Bank

This block holds the control state of a power-management unit that is driven from a two-wire serial power-management bus. A bus slave, outside this block, decodes frames into a 4-bit address and an 8-bit data byte. It then strobes either the write port or the read port of this bank. The bank keeps sixteen byte-wide locations. Each location has its own rule for which bits may be written, which bits are held at zero, and whether it answers reads from storage, with a constant, or not at all.

The stored fields are also driven out continuously as decoded control vectors for the regulators:
- core and DVS switcher voltage codes
- four LDO level codes
- signed N-well and P-well bias fields
- per-channel PFM/PWM force pairs
- regulator enables
- P-well sink-current selection
- general-purpose output levels

A load-defaults strobe from the unit's operating-state sequencer puts every writable location back to its power-on value.

Top module: `pmic_regbank`

## Requirements
- R1: After reset the locations read as follows: address 0 = 0x7F, 2 = 0x60, 7 = 0x78, 8 = 0x28, 10 = 0x7F, 11 = 0x3F, 12 = 0x78, 3 = 0x0F, 4 = 0x01. Every other location reads 0x00.
- R2: A load-defaults pulse restores the R1 values in the next cycle. It takes priority over a write issued in the same cycle.
- R3: Addresses 0 and 10 hold 7-bit voltage codes. Bit 7 always reads 0, and any value written to it is discarded. `core_code` and `dvs_code` show bits 6:0 of these two locations.
- R4: At addresses 2, 7, 8 and 12 only bits 6:3 can be written, and bits 7 and 2:0 always read 0. `mem_code`, `io_code`, `pll_code` and `aux_code` show bits 6:3 of these locations, in that order.
- R5: Address 3 always reads 0x0F and address 4 always reads 0x01. Writes to either address change nothing and raise no error.
- R6: Addresses 1 and 14 ignore writes. A read of either returns an all-zero byte with `rd_valid` low.
- R7: Read data and `rd_valid` appear in the cycle after `rd_en` is sampled. `rd_valid` is high for every address other than 1 and 14, and it is low in any cycle that does not follow a read strobe.
- R8: At address 9 only bits 3:0 can be written. `core_force` shows bits 3:2 and `dvs_force` shows bits 1:0.
- R9: At address 11 only bits 5:0 can be written. `reg_en` shows them with this bit order: 5 = DVS switcher, 4 = LDO4, 3 = LDO1, 2 = P-well bias, 1 = N-well bias, 0 = memory-retention regulator.
- R10: At addresses 5 and 6 bits 7:2 can be written and bits 1:0 read 0. `nwell_bias` and `pwell_bias` show bits 7:2, with bit 7 as the sign.
- R11: At address 13 bits 5:0 can be written and bits 7:6 read 0. `pwell_sink` shows bits 5:4 and `gpo` shows bits 3:0.
- R12: Address 15 is fully writable. A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_dflt | input | 1 | Restore power-on values |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Response flag, low for no-response reads |
| core_code | output | 7 | Core switcher voltage code |
| dvs_code | output | 7 | DVS switcher voltage code |
| mem_code | output | 4 | Memory-retention LDO level |
| io_code | output | 4 | I/O LDO level |
| pll_code | output | 4 | PLL LDO level |
| aux_code | output | 4 | Auxiliary LDO level |
| nwell_bias | output | 6 | N-well bias, sign plus magnitude |
| pwell_bias | output | 6 | P-well bias, sign plus magnitude |
| core_force | output | 2 | Core channel PFM/PWM force pair |
| dvs_force | output | 2 | DVS channel PFM/PWM force pair |
| reg_en | output | 6 | Regulator enables |
| pwell_sink | output | 2 | P-well sink-current select |
| gpo | output | 4 | General-purpose output levels |

## Verification
The bench builds the bank with its default widths: 8 data bits and 4 address bits. Those widths are the only ones the elaboration check accepts, so every one of the sixteen locations and every mask boundary is reachable from the ports. The bench writes all-ones and patterned bytes into each class of location, so that discarded bits, constant answers and silent locations each show up in the read data. It also places a read on the same cycle as a write, and a load-defaults strobe on the same cycle as a write, to fix the priority ordering.

// File: rtl/pmic_rb_pkg.sv
package pmic_rb_pkg;

   localparam int RB_DW   = 8;
   localparam int RB_AW   = 4;
   localparam int RB_NREG = 1 << RB_AW;

   typedef enum logic [1:0] {
      RK_STORE = 2'd0,
      RK_CONST = 2'd1,
      RK_NONE  = 2'd2
   } rd_kind_t;

   // Writable bits of each location
   function automatic logic [RB_DW-1:0] rb_wmask(input logic [RB_AW-1:0] a);
      case (a)
         4'd0, 4'd10:                return 8'h7F;
         4'd2, 4'd7, 4'd8, 4'd12:    return 8'h78;
         4'd5, 4'd6:                 return 8'hFC;
         4'd9:                       return 8'h0F;
         4'd11, 4'd13:               return 8'h3F;
         4'd15:                      return 8'hFF;
         default:                    return 8'h00;
      endcase
   endfunction

   // Power-on value of each location
   function automatic logic [RB_DW-1:0] rb_dflt(input logic [RB_AW-1:0] a);
      case (a)
         4'd0, 4'd10:                return 8'h7F;
         4'd2:                       return 8'h60;
         4'd7, 4'd12:                return 8'h78;
         4'd8:                       return 8'h28;
         4'd11:                      return 8'h3F;
         default:                    return 8'h00;
      endcase
   endfunction

   function automatic rd_kind_t rb_kind(input logic [RB_AW-1:0] a);
      case (a)
         4'd3, 4'd4:                 return RK_CONST;
         4'd1, 4'd14:                return RK_NONE;
         default:                    return RK_STORE;
      endcase
   endfunction

   function automatic logic [RB_DW-1:0] rb_const(input logic [RB_AW-1:0] a);
      case (a)
         4'd3:                       return 8'h0F;
         4'd4:                       return 8'h01;
         default:                    return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/pmic_rb_cell.sv
module pmic_rb_cell #(
   parameter int               DW    = 8,
   parameter logic [DW-1:0]    WMASK = '1,
   parameter logic [DW-1:0]    DFLT  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   initial begin
      if ((DFLT & ~WMASK) != '0)
         $fatal(1, "pmic_rb_cell: default sets bits outside write mask");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= DFLT;
      else if (load)   q <= DFLT;
      else if (we)     q <= d & WMASK;
   end

endmodule

// File: rtl/pmic_rb_rdport.sv
module pmic_rb_rdport
   import pmic_rb_pkg::*;
#(
   parameter int DW   = RB_DW,
   parameter int AW   = RB_AW,
   localparam int NR  = 1 << AW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic [AW-1:0]          rd_addr,
   input  logic [NR-1:0][DW-1:0]  regs,
   output logic [DW-1:0]          rd_data,
   output logic                   rd_valid
);

   logic [DW-1:0] nxt_data;
   logic          nxt_valid;

   always_comb begin
      unique case (rb_kind(rd_addr))
         RK_CONST: begin nxt_data = rb_const(rd_addr); nxt_valid = 1'b1; end
         RK_NONE:  begin nxt_data = '0;                nxt_valid = 1'b0; end
         default:  begin nxt_data = regs[rd_addr];     nxt_valid = 1'b1; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en & nxt_valid;
         if (rd_en) rd_data <= nxt_data;
      end
   end

endmodule

// File: rtl/pmic_rb_decode.sv
module pmic_rb_decode #(
   parameter int VW  = 7,
   parameter int LW  = 4,
   parameter int BW  = 6
) (
   input  logic [VW-1:0] core_f,
   input  logic [VW-1:0] dvs_f,
   input  logic [LW-1:0] mem_f,
   input  logic [LW-1:0] io_f,
   input  logic [LW-1:0] pll_f,
   input  logic [LW-1:0] aux_f,
   input  logic [BW-1:0] nw_f,
   input  logic [BW-1:0] pw_f,
   input  logic [3:0]    force_f,
   input  logic [5:0]    en_f,
   input  logic [5:0]    gpo_f,
   output logic [VW-1:0] core_code,
   output logic [VW-1:0] dvs_code,
   output logic [LW-1:0] mem_code,
   output logic [LW-1:0] io_code,
   output logic [LW-1:0] pll_code,
   output logic [LW-1:0] aux_code,
   output logic [BW-1:0] nwell_bias,
   output logic [BW-1:0] pwell_bias,
   output logic [1:0]    core_force,
   output logic [1:0]    dvs_force,
   output logic [5:0]    reg_en,
   output logic [1:0]    pwell_sink,
   output logic [3:0]    gpo
);

   assign core_code  = core_f;
   assign dvs_code   = dvs_f;
   assign mem_code   = mem_f;
   assign io_code    = io_f;
   assign pll_code   = pll_f;
   assign aux_code   = aux_f;
   assign nwell_bias = nw_f;
   assign pwell_bias = pw_f;
   assign core_force = force_f[3:2];
   assign dvs_force  = force_f[1:0];
   assign reg_en     = en_f;
   assign pwell_sink = gpo_f[5:4];
   assign gpo        = gpo_f[3:0];

endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
   import pmic_rb_pkg::*;
#(
   parameter int DATA_W = RB_DW,
   parameter int ADDR_W = RB_AW,
   localparam int NREG  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_dflt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [6:0]        core_code,
   output logic [6:0]        dvs_code,
   output logic [3:0]        mem_code,
   output logic [3:0]        io_code,
   output logic [3:0]        pll_code,
   output logic [3:0]        aux_code,
   output logic [5:0]        nwell_bias,
   output logic [5:0]        pwell_bias,
   output logic [1:0]        core_force,
   output logic [1:0]        dvs_force,
   output logic [5:0]        reg_en,
   output logic [1:0]        pwell_sink,
   output logic [3:0]        gpo
);

   generate
      if (DATA_W != RB_DW || ADDR_W != RB_AW) begin : g_bad_cfg
         initial $fatal(1, "pmic_regbank: width parameters must match the map");
      end
   endgenerate

   logic [NREG-1:0][DATA_W-1:0] regs;

   for (genvar i = 0; i < NREG; i++) begin : g_loc
      pmic_rb_cell #(
         .DW    (DATA_W),
         .WMASK (rb_wmask(ADDR_W'(i))),
         .DFLT  (rb_dflt(ADDR_W'(i)))
      ) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_dflt),
         .we    (wr_en && (wr_addr == ADDR_W'(i))),
         .d     (wr_data),
         .q     (regs[i])
      );
   end

   pmic_rb_rdport #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .regs     (regs),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   pmic_rb_decode u_dec (
      .core_f     (regs[0][6:0]),
      .dvs_f      (regs[10][6:0]),
      .mem_f      (regs[2][6:3]),
      .io_f       (regs[7][6:3]),
      .pll_f      (regs[8][6:3]),
      .aux_f      (regs[12][6:3]),
      .nw_f       (regs[5][7:2]),
      .pw_f       (regs[6][7:2]),
      .force_f    (regs[9][3:0]),
      .en_f       (regs[11][5:0]),
      .gpo_f      (regs[13][5:0]),
      .core_code  (core_code),
      .dvs_code   (dvs_code),
      .mem_code   (mem_code),
      .io_code    (io_code),
      .pll_code   (pll_code),
      .aux_code   (aux_code),
      .nwell_bias (nwell_bias),
      .pwell_bias (pwell_bias),
      .core_force (core_force),
      .dvs_force  (dvs_force),
      .reg_en     (reg_en),
      .pwell_sink (pwell_sink),
      .gpo        (gpo)
   );

endmodule

// File: rtl/pmic_regbank_chk.sv
module pmic_regbank_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       load_dflt,
   input logic       wr_en,
   input logic [3:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       rd_en,
   input logic [3:0] rd_addr,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic [6:0] core_code,
   input logic [5:0] reg_en
);

   // R7
   valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en));

   // R7
   valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != 4'd1 && rd_addr != 4'd14) |=> rd_valid);

   // R6
   silent_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr == 4'd1 || rd_addr == 4'd14)) |=> (!rd_valid && rd_data == 8'h00));

   // R5
   status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 4'd3) |=> (rd_data == 8'h0F));

   // R5
   version_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 4'd4) |=> (rd_data == 8'h01));

   // R3
   core_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'd0 && !load_dflt) |=> ({1'b0, core_code} == ($past(wr_data) & 8'h7F)));

   // R2
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_dflt |=> (core_code == 7'h7F && reg_en == 6'h3F));

endmodule

bind pmic_regbank pmic_regbank_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_dflt (load_dflt),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .core_code (core_code),
   .reg_en    (reg_en)
);

// File: tb/tb_pmic_regbank.sv
module tb_pmic_regbank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_dflt = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic [6:0] core_code, dvs_code;
   logic [3:0] mem_code, io_code, pll_code, aux_code;
   logic [5:0] nwell_bias, pwell_bias;
   logic [1:0] core_force, dvs_force, pwell_sink;
   logic [5:0] reg_en;
   logic [3:0] gpo;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pmic_regbank dut (
      .clk(clk), .rst_n(rst_n), .load_dflt(load_dflt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .core_code(core_code), .dvs_code(dvs_code), .mem_code(mem_code),
      .io_code(io_code), .pll_code(pll_code), .aux_code(aux_code),
      .nwell_bias(nwell_bias), .pwell_bias(pwell_bias),
      .core_force(core_force), .dvs_force(dvs_force), .reg_en(reg_en),
      .pwell_sink(pwell_sink), .gpo(gpo)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp, input logic expv);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check({tag, " data"}, 32'(rd_data), 32'(exp));
      check({tag, " valid"}, 32'(rd_valid), 32'(expv));
   endtask

   task automatic t_reset;   // R1
      logic [7:0] exp [16] = '{8'h7F, 8'h00, 8'h60, 8'h0F, 8'h01, 8'h00, 8'h00, 8'h78,
                               8'h28, 8'h00, 8'h7F, 8'h3F, 8'h78, 8'h00, 8'h00, 8'h00};
      for (int i = 0; i < 16; i++)
         rd("R1 reset read", 4'(i), exp[i], (i != 1 && i != 14));
      check("R1 core_code", 32'(core_code), 32'h7F);
      check("R1 io_code", 32'(io_code), 32'hF);
      check("R1 pll_code", 32'(pll_code), 32'h5);
      check("R1 reg_en", 32'(reg_en), 32'h3F);
   endtask

   task automatic t_voltage; // R3
      wr(4'd0, 8'hFF);
      check("R3 core_code", 32'(core_code), 32'h7F);
      rd("R3 addr0", 4'd0, 8'h7F, 1'b1);
      wr(4'd10, 8'h80);
      check("R3 dvs_code", 32'(dvs_code), 32'h00);
      rd("R3 addr10", 4'd10, 8'h00, 1'b1);
      wr(4'd0, 8'h2A);
      check("R3 core_code pattern", 32'(core_code), 32'h2A);
   endtask

   task automatic t_ldo;     // R4
      wr(4'd2, 8'hFF);
      rd("R4 addr2", 4'd2, 8'h78, 1'b1);
      check("R4 mem_code", 32'(mem_code), 32'hF);
      wr(4'd7, 8'h07);
      rd("R4 addr7", 4'd7, 8'h00, 1'b1);
      check("R4 io_code", 32'(io_code), 32'h0);
      wr(4'd8, 8'h55);
      rd("R4 addr8", 4'd8, 8'h50, 1'b1);
      check("R4 pll_code", 32'(pll_code), 32'hA);
      wr(4'd12, 8'hAA);
      rd("R4 addr12", 4'd12, 8'h28, 1'b1);
      check("R4 aux_code", 32'(aux_code), 32'h5);
   endtask

   task automatic t_readonly; // R5
      wr(4'd3, 8'hAA);
      rd("R5 addr3", 4'd3, 8'h0F, 1'b1);
      wr(4'd4, 8'hFE);
      rd("R5 addr4", 4'd4, 8'h01, 1'b1);
   endtask

   task automatic t_noresp;  // R6
      wr(4'd1, 8'hFF);
      rd("R6 addr1", 4'd1, 8'h00, 1'b0);
      wr(4'd14, 8'h5A);
      rd("R6 addr14", 4'd14, 8'h00, 1'b0);
   endtask

   task automatic t_timing;  // R7
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 4'd11;
      check("R7 valid before edge", 32'(rd_valid), 32'h0);
      @(negedge clk);
      rd_en = 1'b0;
      check("R7 data one cycle later", 32'(rd_data), 32'h3F);
      check("R7 valid one cycle later", 32'(rd_valid), 32'h1);
      @(negedge clk);
      check("R7 valid drops when idle", 32'(rd_valid), 32'h0);
   endtask

   task automatic t_force;   // R8
      wr(4'd9, 8'hFF);
      rd("R8 addr9", 4'd9, 8'h0F, 1'b1);
      check("R8 core_force", 32'(core_force), 32'h3);
      check("R8 dvs_force", 32'(dvs_force), 32'h3);
      wr(4'd9, 8'h06);
      check("R8 core_force 01", 32'(core_force), 32'h1);
      check("R8 dvs_force 10", 32'(dvs_force), 32'h2);
   endtask

   task automatic t_enable;  // R9
      wr(4'd11, 8'hC5);
      rd("R9 addr11", 4'd11, 8'h05, 1'b1);
      check("R9 reg_en mem+pwell", 32'(reg_en), 32'h05);
      wr(4'd11, 8'h20);
      check("R9 reg_en dvs only", 32'(reg_en), 32'h20);
   endtask

   task automatic t_bias;    // R10
      wr(4'd5, 8'hFF);
      rd("R10 addr5", 4'd5, 8'hFC, 1'b1);
      check("R10 nwell_bias", 32'(nwell_bias), 32'h3F);
      wr(4'd6, 8'h87);
      rd("R10 addr6", 4'd6, 8'h84, 1'b1);
      check("R10 pwell_bias", 32'(pwell_bias), 32'h21);
   endtask

   task automatic t_gpo;     // R11
      wr(4'd13, 8'hDA);
      rd("R11 addr13", 4'd13, 8'h1A, 1'b1);
      check("R11 pwell_sink", 32'(pwell_sink), 32'h1);
      check("R11 gpo", 32'(gpo), 32'hA);
   endtask

   task automatic t_collide; // R12
      wr(4'd15, 8'h5A);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd15; wr_data = 8'hA5;
      rd_en = 1'b1; rd_addr = 4'd15;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R12 read sees old value", 32'(rd_data), 32'h5A);
      rd("R12 addr15 full write", 4'd15, 8'hA5, 1'b1);
   endtask

   task automatic t_dflt;    // R2
      wr(4'd11, 8'h00);
      wr(4'd8, 8'h00);
      @(negedge clk);
      load_dflt = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h11;
      @(negedge clk);
      load_dflt = 1'b0; wr_en = 1'b0;
      check("R2 core_code restored", 32'(core_code), 32'h7F);
      check("R2 reg_en restored", 32'(reg_en), 32'h3F);
      rd("R2 addr8 restored", 4'd8, 8'h28, 1'b1);
      rd("R2 addr15 restored", 4'd15, 8'h00, 1'b1);
      rd("R2 addr13 restored", 4'd13, 8'h00, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_voltage();
      t_ldo();
      t_readonly();
      t_noresp();
      t_timing();
      t_force();
      t_enable();
      t_bias();
      t_gpo();
      t_collide();
      t_dflt();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule